// File: doc/BRIEF.md
# USB Bus Reset and Resume Detector

This block sits beside a full-speed USB device port and watches the D+ and D- lines after they pass through two-flop synchronizers. It recognizes a host bus reset, meaning a single-ended zero held longer than 2.5 µs. On a bus reset it clears the device address and the configured state. While the port is suspended with its clock gated off, it catches a K-state without any clock edge and raises a wake request. After firmware restarts the clock, it confirms the wake as a genuine host resume only if the K-state is still present one threshold period later.

Firmware controls the block through a small synchronous write port with four word addresses. These hold a control word, interrupt enables, write-1-to-clear event flags, and the device address with its configured bit. All state is visible on plain output pins. A control bit drives the remote-wakeup K-state for as long as it stays set. A self-clearing soft-reset bit returns the block to its default mode. No data stream crosses the block's edge, so it has no valid/ready handshake. Every pin is a level that is sampled or updated at the rising clock edge.

Duration thresholds are counted in clock cycles: THR = CLK_HZ / 400000, which gives 120 cycles at 48 MHz. Line states decode as follows:
- SE0: D+ = 0, D- = 0
- J: D+ = 1, D- = 0
- K: D+ = 0, D- = 1
- Both lines high: not used as a signalling state.

Top module: `usbwk_top`

## Requirements
- R1: A held SE0 sets event flag bit 0 (bus reset) at the (THR+3)th rising edge after SE0 is first applied to the pins: two synchronizer stages, then THR+1 counted cycles. The flag is not set at the (THR+2)th edge, and it is set once per SE0 period.
- R2: When a bus reset is detected, dev_addr is cleared to 0 and configured is cleared. This takes priority over a write to the address word (address 3: data[6:0] is the address, data[7] is configured) in the same cycle.
- R3: The event flags are read at flags[2:0] and are sticky: bit 0 is bus reset, bit 1 is confirmed resume, bit 2 is low-power wake. Writing a 1 to a bit at address 2 clears that bit. Writing a 0 leaves it unchanged. A new event in the same cycle as a clear leaves the flag set.
- R4: Any change of line state restarts the duration count. A one-cycle J inside an SE0 run therefore prevents detection until a fresh run exceeds THR.
- R5: J, K and both-lines-high held for any length of time while the block is not suspended set no flag.
- R6: With suspend set (control bit 2) and clk_en clear (control bit 3), a K on the raw pins sets flag bit 2 and wake_req at once, without a clock edge.
- R7: Once clk_en is set again with a low-power wake pending, the block samples the line THR+1 cycles later. If the line is then K, flag bit 1 is set. If it is not K, the wake is dropped as a transient and bit 1 stays clear.
- R8: Control bit 1 drives the K-state: while it is set, drv_en=1, drv_dp=0 and drv_dm=1. When it is cleared, drv_en=0.
- R9: Writing 1 to control bit 0 (address 0) performs a module reset: ien=0, clk_en=1, reg_en=0, suspend=0, drive off, all flags 0, dev_addr=0, configured=0. Control bit 4 is reg_en.
- R10: irq is high exactly when some flag bit is set together with the matching enable bit (address 1, data[2:0]).
- R11: After power-on reset: flags 0, ien 0, clk_en 1, reg_en 0, suspend 0, dev_addr 0, configured 0, irq 0, drv_en 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp_in | input | 1 | Raw D+ line level |
| dm_in | input | 1 | Raw D- line level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Word address: 0 control, 1 enables, 2 flags, 3 address |
| wr_data | input | 8 | Write data |
| irq | output | 1 | Masked interrupt request |
| wake_req | output | 1 | Low-power wake request (mirrors flag bit 2) |
| flags | output | 3 | Event flags {lowpower wake, resume, bus reset} |
| ien | output | 3 | Interrupt enables |
| dev_addr | output | 7 | Device address |
| configured | output | 1 | Configured state |
| clk_en | output | 1 | Clock-enable output |
| reg_en | output | 1 | Regulator-enable output |
| suspend | output | 1 | Suspend control bit |
| drv_en | output | 1 | Line driver enable |
| drv_dp | output | 1 | Driven D+ level |
| drv_dm | output | 1 | Driven D- level |

## Verification
Two pairs of functions can fall in the same cycle. In the first pair, a bus reset is detected in the same cycle that firmware writes the address word. In the second pair, a bus reset is detected in the same cycle that firmware clears the reset flag. The bench provokes each collision by holding SE0 for exactly THR+2 edges and then placing the write so that it lands on the (THR+3)th edge, where detection fires. It judges the result by requiring that the address reads zero and that the flag stays set. Just before the collision it also checks that the flag is still clear, which pins the detection edge on both sides.

// File: rtl/usbwk_pkg.sv
package usbwk_pkg;
  typedef enum logic [1:0] {
    LS_SE0 = 2'd0,
    LS_J   = 2'd1,
    LS_K   = 2'd2,
    LS_BAD = 2'd3
  } line_t;

  localparam int FLAG_W = 3;
  localparam int FB_RST = 0;
  localparam int FB_RES = 1;
  localparam int FB_LPW = 2;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_IEN  = 2'd1;
  localparam logic [1:0] A_FLAG = 2'd2;
  localparam logic [1:0] A_ADDR = 2'd3;

  function automatic line_t decode_line(input logic dp, input logic dm);
    case ({dp, dm})
      2'b00:   decode_line = LS_SE0;
      2'b10:   decode_line = LS_J;
      2'b01:   decode_line = LS_K;
      default: decode_line = LS_BAD;
    endcase
  endfunction
endpackage

// File: rtl/usbwk_sync.sv
module usbwk_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= INIT;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/usbwk_linemon.sv
module usbwk_linemon
  import usbwk_pkg::*;
#(
  parameter int THR = 120,
  localparam int CW = $clog2(THR + 2)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  logic  clr,
  input  line_t state,
  output logic  rst_evt,
  output logic  is_k
);
  line_t         st_q;
  logic [CW-1:0] cnt;
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW-1:0] CTHR = CW'(THR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= LS_J;
      cnt  <= '0;
    end else if (clr) begin
      st_q <= LS_J;
      cnt  <= '0;
    end else if (run) begin
      st_q <= state;
      if (state != st_q) cnt <= CW'(1);
      else if (cnt != CMAX) cnt <= cnt + CW'(1);
    end
  end

  assign rst_evt = run && !clr && (state == LS_SE0) && (st_q == LS_SE0) && (cnt == CTHR);
  assign is_k    = (state == LS_K);

  p_one_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt |=> !rst_evt);
endmodule

// File: rtl/usbwk_wake.sv
module usbwk_wake #(
  parameter int THR = 120,
  localparam int CW = $clog2(THR + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic dp_raw,
  input  logic dm_raw,
  input  logic suspend,
  input  logic clk_en,
  input  logic line_is_k,
  input  logic lp_clr,
  output logic lp_flag,
  output logic res_evt
);
  logic          pend;
  logic          lp_wake;
  logic          win_end;
  logic [CW-1:0] wcnt;

  assign lp_wake = suspend & ~clk_en & ~dp_raw & dm_raw;
  assign win_end = pend && clk_en && (wcnt == CW'(THR));

  always_ff @(posedge clk or negedge rst_n or posedge lp_wake) begin
    if (!rst_n) begin
      lp_flag <= 1'b0;
      pend    <= 1'b0;
    end else if (lp_wake) begin
      lp_flag <= 1'b1;
      pend    <= 1'b1;
    end else if (clr) begin
      lp_flag <= 1'b0;
      pend    <= 1'b0;
    end else begin
      if (lp_clr) lp_flag <= 1'b0;
      if (win_end) pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wcnt <= '0;
    else if (clr || !pend || !clk_en || win_end) wcnt <= '0;
    else wcnt <= wcnt + CW'(1);
  end

  assign res_evt = win_end && line_is_k && !clr;

  p_window_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && !lp_wake) |=> !pend);
endmodule

// File: rtl/usbwk_regs.sv
module usbwk_regs
  import usbwk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rst_evt,
  input  logic              res_evt,
  output logic              soft_clr,
  output logic              lp_clr,
  output logic [1:0]        ev_q,
  output logic [FLAG_W-1:0] ien,
  output logic [6:0]        dev_addr,
  output logic              cfg,
  output logic              resume_drv,
  output logic              suspend,
  output logic              clk_en,
  output logic              reg_en
);
  logic       w_ctrl, w_ien, w_flag, w_addr;
  logic [1:0] ev_set;
  logic [1:0] ev_clr;

  assign w_ctrl   = wr_en && (wr_addr == A_CTRL);
  assign w_ien    = wr_en && (wr_addr == A_IEN);
  assign w_flag   = wr_en && (wr_addr == A_FLAG);
  assign w_addr   = wr_en && (wr_addr == A_ADDR);
  assign soft_clr = w_ctrl && wr_data[0];
  assign lp_clr   = w_flag && wr_data[FB_LPW];
  assign ev_set   = {res_evt, rst_evt};
  assign ev_clr   = w_flag ? wr_data[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || soft_clr) begin
      ien        <= '0;
      resume_drv <= 1'b0;
      suspend    <= 1'b0;
      clk_en     <= 1'b1;
      reg_en     <= 1'b0;
    end else begin
      if (w_ien) ien <= wr_data[FLAG_W-1:0];
      if (w_ctrl) begin
        resume_drv <= wr_data[1];
        suspend    <= wr_data[2];
        clk_en     <= wr_data[3];
        reg_en     <= wr_data[4];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_addr <= '0;
      cfg      <= 1'b0;
    end else if (soft_clr || rst_evt) begin
      dev_addr <= '0;
      cfg      <= 1'b0;
    end else if (w_addr) begin
      dev_addr <= wr_data[6:0];
      cfg      <= wr_data[7];
    end
  end

  genvar b;
  generate
    for (b = 0; b < 2; b++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev_q[b] <= 1'b0;
        else if (soft_clr) ev_q[b] <= 1'b0;
        else ev_q[b] <= (ev_q[b] & ~ev_clr[b]) | ev_set[b];
      end
    end
  endgenerate

  p_addr_cleared_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt |=> (dev_addr == 7'd0) && !cfg);
  p_flag_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_evt && !soft_clr) |=> ev_q[FB_RST]);
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ev_q[FB_RST]) |-> $past(w_flag && wr_data[FB_RST]) || $past(soft_clr));
  p_default_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (ien == '0) && clk_en && !reg_en && !resume_drv);
endmodule

// File: rtl/usbwk_top.sv
module usbwk_top
  import usbwk_pkg::*;
#(
  parameter int CLK_HZ = 48_000_000,
  localparam int THR = CLK_HZ / 400_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dp_in,
  input  logic       dm_in,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       irq,
  output logic       wake_req,
  output logic [2:0] flags,
  output logic [2:0] ien,
  output logic [6:0] dev_addr,
  output logic       configured,
  output logic       clk_en,
  output logic       reg_en,
  output logic       suspend,
  output logic       drv_en,
  output logic       drv_dp,
  output logic       drv_dm
);
  logic [1:0] line_s;
  line_t      state;
  logic       rst_evt, res_evt, is_k, soft_clr, lp_clr, lp_flag, resume_drv;
  logic [1:0] ev_q;

  usbwk_sync #(.W(2), .STAGES(2), .INIT(2'b10)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({dp_in, dm_in}), .q(line_s)
  );

  assign state = decode_line(line_s[1], line_s[0]);

  usbwk_linemon #(.THR(THR)) u_mon (
    .clk(clk), .rst_n(rst_n), .run(clk_en), .clr(soft_clr), .state(state),
    .rst_evt(rst_evt), .is_k(is_k)
  );

  usbwk_wake #(.THR(THR)) u_wake (
    .clk(clk), .rst_n(rst_n), .clr(soft_clr), .dp_raw(dp_in), .dm_raw(dm_in),
    .suspend(suspend), .clk_en(clk_en), .line_is_k(is_k), .lp_clr(lp_clr),
    .lp_flag(lp_flag), .res_evt(res_evt)
  );

  usbwk_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rst_evt(rst_evt), .res_evt(res_evt), .soft_clr(soft_clr), .lp_clr(lp_clr),
    .ev_q(ev_q), .ien(ien), .dev_addr(dev_addr), .cfg(configured),
    .resume_drv(resume_drv), .suspend(suspend), .clk_en(clk_en), .reg_en(reg_en)
  );

  assign flags    = {lp_flag, ev_q};
  assign wake_req = lp_flag;
  assign irq      = |(flags & ien);
  assign drv_en   = resume_drv;
  assign drv_dp   = 1'b0;
  assign drv_dm   = resume_drv;

  p_drive_k_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> (drv_dm && !drv_dp));
  p_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 3'd0) |-> !irq);
endmodule

// File: tb/sim_usbwk_top.sv
module sim_usbwk_top;
  localparam int CLK_HZ = 48_000_000;
  localparam int THR = CLK_HZ / 400_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dp_in = 1'b1, dm_in = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic irq, wake_req, configured, clk_en, reg_en, suspend, drv_en, drv_dp, drv_dm;
  logic [2:0] flags, ien;
  logic [6:0] dev_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  usbwk_top #(.CLK_HZ(CLK_HZ)) u0 (
    .clk(clk), .rst_n(rst_n), .dp_in(dp_in), .dm_in(dm_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq), .wake_req(wake_req),
    .flags(flags), .ien(ien), .dev_addr(dev_addr), .configured(configured),
    .clk_en(clk_en), .reg_en(reg_en), .suspend(suspend), .drv_en(drv_en),
    .drv_dp(drv_dp), .drv_dm(drv_dm)
  );

  // {dp, dm, hold edges, expected bus-reset flag}
  localparam logic [11:0] VEC [0:6] = '{
    {1'b0, 1'b0, 9'(THR - 4), 1'b0},
    {1'b0, 1'b0, 9'(THR + 2), 1'b0},
    {1'b0, 1'b0, 9'(THR + 3), 1'b1},
    {1'b0, 1'b0, 9'(THR + 8), 1'b1},
    {1'b1, 1'b0, 9'(THR + 8), 1'b0},
    {1'b0, 1'b1, 9'(THR + 8), 1'b0},
    {1'b1, 1'b1, 9'(THR + 8), 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_and_clear();
    dp_in = 1'b1; dm_in = 1'b0;
    wait_n(6);
    wr(2'd2, 8'h07);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    // R11 reset state
    chk("R11 flags", flags, 0);
    chk("R11 ien", ien, 0);
    chk("R11 clk_en", clk_en, 1);
    chk("R11 reg_en", reg_en, 0);
    chk("R11 addr", {configured, dev_addr}, 0);
    chk("R11 irq/drv", {irq, drv_en, suspend}, 0);

    // R1 / R5 table walk
    for (int i = 0; i < 7; i++) begin
      dp_in = VEC[i][11]; dm_in = VEC[i][10];
      wait_n(int'(VEC[i][9:1]));
      chk($sformatf("R1/R5 vec%0d", i), flags[0], VEC[i][0]);
      chk($sformatf("R5 vec%0d other flags", i), flags[2:1], 0);
      idle_and_clear();
    end

    // R4 glitch restarts count
    dp_in = 1'b0; dm_in = 1'b0; wait_n(THR);
    dp_in = 1'b1; wait_n(1);
    dp_in = 1'b0; wait_n(THR);
    chk("R4 glitch", flags[0], 0);
    idle_and_clear();
    chk("R4 after idle", flags[0], 0);

    // R2 address write collides with reset detection
    wr(2'd3, 8'h85);
    chk("R2 addr written", {configured, dev_addr}, 8'h85);
    dp_in = 1'b0; dm_in = 1'b0; wait_n(THR + 2);
    chk("R1 not yet at THR+2", flags[0], 0);
    wr(2'd3, 8'h9A);
    chk("R2 reset wins addr", {configured, dev_addr}, 0);
    chk("R1 set at THR+3", flags[0], 1);
    idle_and_clear();

    // R3 clear collides with new detection
    dp_in = 1'b0; dm_in = 1'b0; wait_n(THR + 2);
    wr(2'd2, 8'h01);
    chk("R3 set wins over clear", flags[0], 1);
    dp_in = 1'b1; dm_in = 1'b0; wait_n(6);
    wr(2'd2, 8'h00);
    chk("R3 write zero no effect", flags[0], 1);

    // R10 masking
    wr(2'd1, 8'h01);
    chk("R10 enabled irq", irq, 1);
    wr(2'd1, 8'h06);
    chk("R10 masked irq", irq, 0);
    wr(2'd2, 8'h01);
    chk("R3 W1C clears", flags[0], 0);
    wr(2'd1, 8'h00);

    // R6 / R7 low-power wake confirmed
    wr(2'd0, 8'h04);
    dp_in = 1'b0; dm_in = 1'b1;
    #2;
    chk("R6 async lp flag", {wake_req, flags[2]}, 2'b11);
    wait_n(1);
    wr(2'd0, 8'h0C);
    wait_n(THR + 10);
    chk("R7 resume confirmed", flags[1], 1);
    idle_and_clear();
    chk("R3 all cleared", flags, 0);

    // R7 transient wake
    wr(2'd0, 8'h04);
    dp_in = 1'b0; dm_in = 1'b1;
    wait_n(1);
    dp_in = 1'b1; dm_in = 1'b0;
    wait_n(4);
    chk("R6 transient lp flag", flags[2], 1);
    wr(2'd0, 8'h0C);
    wait_n(THR + 10);
    chk("R7 transient rejected", flags[1], 0);
    wr(2'd2, 8'h07);

    // R8 remote wakeup drive
    wr(2'd0, 8'h0A);
    chk("R8 drive K", {drv_en, drv_dp, drv_dm}, 3'b101);
    wr(2'd0, 8'h08);
    chk("R8 drive off", drv_en, 0);

    // R9 module reset
    wr(2'd1, 8'h07);
    wr(2'd3, 8'h85);
    wr(2'd0, 8'h16);
    dp_in = 1'b0; dm_in = 1'b1;
    #2;
    chk("R9 setup lp", flags[2], 1);
    dp_in = 1'b1; dm_in = 1'b0;
    wr(2'd0, 8'h01);
    chk("R9 ien", ien, 0);
    chk("R9 clk/reg/susp", {clk_en, reg_en, suspend, drv_en}, 4'b1000);
    chk("R9 flags", flags, 0);
    chk("R9 addr", {configured, dev_addr}, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule